// File: doc/BRIEF.md
# Coarse Quarter/Eighth-Rate Complex Frequency Shifter

This block moves a complex baseband stream up or down in frequency by exactly one quarter or one eighth of its own sample rate. It sits after the interpolation filters, runs at the converter update rate and forms the coarse stage of a two-stage tuning chain. A separate fine-resolution modulator supplies the small frequency offset. Together the two stages can place the signal anywhere up to roughly 73% of the converter's Nyquist band.

The input is complex, so the shift moves only the wanted component. For example, a +6 MHz tone shifted by a quarter of the rate lands at Fs/4 + 6 MHz, and nothing appears at Fs/4 − 6 MHz. The quarter-rate rotation needs no multiplier: only swaps and sign changes. The eighth-rate rotation adds a single constant 1/√2 scaling on alternate samples. A bypass mode passes samples through unchanged with the same delay, so a mode switch does not move the stream in time.

Top module: `coarse_upconv`

## Requirements
- R1: Every mode has a latency of exactly two clock cycles. A sample presented with `inValid` high appears on `outI`/`outQ` two cycles later, with `outValid` high, and `outValid` is low two cycles after a cycle with `inValid` low. With `modeSel` = 0 (bypass), the output equals the input.
- R2: With `modeSel` = 1 (quarter rate) and `sbDown` = 0, successive valid samples starting at phase 0 give (I,Q), (−Q,I), (−I,−Q), (Q,−I), and then the cycle repeats.
- R3: With `sbDown` = 1, the rotation runs in the opposite direction. In quarter-rate mode, starting at phase 0, successive samples give (I,Q), (Q,−I), (−I,−Q), (−Q,I).
- R4: With `modeSel` = 2 (eighth rate), valid sample number k is rotated by k·45°, or by −k·45° when `sbDown` = 1. On odd eighths, the 45° part is computed first as I' = round(c·(I−Q)) and Q' = round(c·(I+Q)), with c = 23170/32768. Rounding adds 16384 before an arithmetic right shift by 15. The remaining multiple of 90° is then applied as in R2.
- R5: The rotation phase advances only on cycles with `inValid` high. Idle cycles leave it unchanged.
- R6: In any cycle where `modeSel` differs from its value in the previous cycle, the phase returns to 0. That cycle's sample, if valid, uses phase 0. A change of `sbDown` alone keeps the phase.
- R7: Results are clipped to the range −32768..32767 rather than wrapping. For example, negating −32768 gives 32767.
- R8: While reset (`rstN` low) is active and after it is released, `outValid`, `outI` and `outQ` are 0 and the phase is 0. The mode before the first cycle counts as bypass.
- R9: `modeSel` = 3 behaves as bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | 16 | Signed in-phase input sample |
| inQ | input | 16 | Signed quadrature input sample |
| modeSel | input | 2 | 0 bypass, 1 quarter-rate shift, 2 eighth-rate shift, 3 bypass |
| sbDown | input | 1 | 1 reverses the rotation direction (downshift) |
| outValid | output | 1 | Output sample strobe |
| outI | output | 16 | Signed rotated in-phase output |
| outQ | output | 16 | Signed rotated quadrature output |

## Verification
The energy property for the quarter-rate mode holds only when neither input component is at its most negative code. It therefore conditions on that, and saturation is left to the bench, which compares exact values. The mode-change and bypass properties assume that `modeSel` is a settled, known value at every rising edge. The bench drives all inputs on the falling edge and holds `inValid` low throughout reset, so that assumption is met. The bench stimulus alternates between runs of valid samples, idle gaps and mode or sideband switches, so that every phase is reached with both clean and clipping values.

// File: rtl/cu_pkg.sv
package cu_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_QUARTER = 2'd1,
    MODE_EIGHTH  = 2'd2,
    MODE_SPARE   = 2'd3
  } modeT;

  // Phase is counted in eighths of a turn.
  localparam int PHASE_W = 3;

  typedef struct packed {
    logic             load;       // sample strobe for this cycle
    logic             oddEighth;  // apply the 45 degree scaling
    logic [1:0]       quarter;    // number of quarter turns after that
  } ctrlT;

  function automatic longint unsigned isqrtFloor(input longint unsigned v);
    longint unsigned r;
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint unsigned t;
      t = r | (64'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  // round(2^fracBits / sqrt(2)), valid for fracBits up to 30
  function automatic int invSqrt2Coef(input int fracBits);
    longint unsigned twice;
    twice = isqrtFloor(64'd1 << (2 * fracBits + 1));
    return int'((twice + 64'd1) >> 1);
  endfunction

endpackage

// File: rtl/cu_ctrl.sv
module cu_ctrl
  import cu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] modeSel,
  input  logic       sbDown,
  output ctrlT       ctrl
);

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] effPhase;
  logic [PHASE_W-1:0] stepMag;
  logic [PHASE_W-1:0] stepVal;
  logic [1:0]         lastMode;
  logic               modeChange;
  logic               rotating;

  assign modeChange = (modeSel != lastMode);
  assign effPhase   = modeChange ? '0 : phase;

  always_comb begin
    case (modeSel)
      MODE_QUARTER: begin stepMag = PHASE_W'(2); rotating = 1'b1; end
      MODE_EIGHTH:  begin stepMag = PHASE_W'(1); rotating = 1'b1; end
      default:      begin stepMag = '0;          rotating = 1'b0; end
    endcase
  end

  assign stepVal = sbDown ? (PHASE_W'(0) - stepMag) : stepMag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= '0;
      lastMode <= MODE_PASS;
    end else begin
      lastMode <= modeSel;
      if (inValid)         phase <= effPhase + stepVal;
      else if (modeChange) phase <= '0;
    end
  end

  always_comb begin
    ctrl.load      = inValid;
    ctrl.oddEighth = rotating & effPhase[0];
    ctrl.quarter   = rotating ? effPhase[2:1] : 2'd0;
  end

endmodule

// File: rtl/cu_scale45.sv
module cu_scale45 #(
  parameter int IN_W   = 17,
  parameter int COEF_W = 16
) (
  input  logic signed [IN_W-1:0] x,
  output logic signed [IN_W-1:0] y
);

  localparam int FRAC   = COEF_W - 1;
  localparam int PROD_W = IN_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] COEF =
    PROD_W'(cu_pkg::invSqrt2Coef(FRAC));
  localparam logic signed [PROD_W-1:0] HALF =
    {{(PROD_W-1){1'b0}}, 1'b1} << (FRAC - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;

  assign prod    = PROD_W'(x) * COEF;
  assign biased  = prod + HALF;
  assign shifted = biased >>> FRAC;
  assign y       = IN_W'(shifted);

endmodule

// File: rtl/cu_quarter.sv
module cu_quarter #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [IN_W-1:0]  b,
  input  logic [1:0]              quarter,
  output logic signed [OUT_W-1:0] yI,
  output logic signed [OUT_W-1:0] yQ
);

  localparam int EXT_W = IN_W + 1;
  localparam logic signed [EXT_W-1:0] MAXV = EXT_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [EXT_W-1:0] MINV = EXT_W'(-(2 ** (OUT_W - 1)));

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [EXT_W-1:0] v);
    if (v > MAXV)      return OUT_W'(MAXV);
    else if (v < MINV) return OUT_W'(MINV);
    else               return OUT_W'(v);
  endfunction

  logic signed [EXT_W-1:0] aExt, bExt, aNeg, bNeg, rotI, rotQ;

  assign aExt = EXT_W'(a);
  assign bExt = EXT_W'(b);
  assign aNeg = -aExt;
  assign bNeg = -bExt;

  always_comb begin
    case (quarter)
      2'd0: begin rotI = aExt; rotQ = bExt; end
      2'd1: begin rotI = bNeg; rotQ = aExt; end
      2'd2: begin rotI = aNeg; rotQ = bNeg; end
      default: begin rotI = bExt; rotQ = aNeg; end
    endcase
  end

  assign yI = clip(rotI);
  assign yQ = clip(rotQ);

endmodule

// File: rtl/cu_datapath.sv
module cu_datapath
  import cu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlT                     ctrl,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  localparam int SUM_W = DATA_W + 1;

  logic signed [SUM_W-1:0] laneRaw    [2];
  logic signed [SUM_W-1:0] laneSum    [2];
  logic signed [SUM_W-1:0] laneScaled [2];
  logic signed [SUM_W-1:0] laneSel    [2];

  assign laneRaw[0] = SUM_W'(inI);
  assign laneRaw[1] = SUM_W'(inQ);

  // Lane 0 carries c*(I-Q), lane 1 carries c*(I+Q).
  for (genvar g = 0; g < 2; g++) begin : gLane
    if (g == 0) begin : gDiff
      assign laneSum[g] = SUM_W'(inI) - SUM_W'(inQ);
    end else begin : gAdd
      assign laneSum[g] = SUM_W'(inI) + SUM_W'(inQ);
    end

    cu_scale45 #(
      .IN_W   (SUM_W),
      .COEF_W (COEF_W)
    ) i_scale (
      .x (laneSum[g]),
      .y (laneScaled[g])
    );

    assign laneSel[g] = ctrl.oddEighth ? laneScaled[g] : laneRaw[g];
  end

  logic signed [SUM_W-1:0] stI, stQ;
  logic [1:0]              stQuarter;
  logic                    stValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stI       <= '0;
      stQ       <= '0;
      stQuarter <= '0;
      stValid   <= 1'b0;
    end else begin
      stI       <= laneSel[0];
      stQ       <= laneSel[1];
      stQuarter <= ctrl.quarter;
      stValid   <= ctrl.load;
    end
  end

  logic signed [DATA_W-1:0] rotI, rotQ;

  cu_quarter #(
    .IN_W  (SUM_W),
    .OUT_W (DATA_W)
  ) i_quarter (
    .a       (stI),
    .b       (stQ),
    .quarter (stQuarter),
    .yI      (rotI),
    .yQ      (rotQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outI     <= '0;
      outQ     <= '0;
      outValid <= 1'b0;
    end else begin
      outI     <= rotI;
      outQ     <= rotQ;
      outValid <= stValid;
    end
  end

endmodule

// File: rtl/coarse_upconv.sv
module coarse_upconv
  import cu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic [1:0]               modeSel,
  input  logic                     sbDown,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);

  ctrlT ctrl;

  cu_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .modeSel (modeSel),
    .sbDown  (sbDown),
    .ctrl    (ctrl)
  );

  cu_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .inI      (inI),
    .inQ      (inQ),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ)
  );

endmodule

// File: rtl/cu_checker.sv
module cu_checker #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inI,
  input logic signed [DATA_W-1:0] inQ,
  input logic [1:0]               modeSel,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ
);

  localparam int EW = 2 * DATA_W + 2;
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [EW-1:0] energyIn, energyOut;
  logic                 passMode, cleanIn;

  assign energyIn  = EW'(inI) * EW'(inI) + EW'(inQ) * EW'(inQ);
  assign energyOut = EW'(outI) * EW'(outI) + EW'(outQ) * EW'(outQ);
  assign passMode  = (modeSel == 2'd0) || (modeSel == 2'd3);
  assign cleanIn   = (inI != MINV) && (inQ != MINV);

  // R1: a valid sample leaves two cycles later
  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R1: no output strobe without an input strobe two cycles before
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);

  // R1 and R9: both bypass codes pass the data untouched
  p_bypass_identity_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && passMode) |-> ##2 (outI == $past(inI, 2) && outQ == $past(inQ, 2)));

  // R2: a quarter turn only swaps and negates, so energy is kept
  p_quarter_energy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 2'd1 && cleanIn) |-> ##2 (energyOut == $past(energyIn, 2)));

  // R6: the first sample after a mode switch is at phase 0
  p_mode_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeSel == 2'd1 && modeSel != $past(modeSel))
      |-> ##2 (outI == $past(inI, 2) && outQ == $past(inQ, 2)));

endmodule

bind coarse_upconv cu_checker #(.DATA_W(DATA_W)) i_checker (.*);

// File: tb/test_coarse_upconv.sv
`timescale 1ns/1ps
module test_coarse_upconv;

  localparam int DW = 16;
  localparam int NV = 41;

  // row: {valid, mode, sbDown, I, Q}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 2'd1, 1'b0, 16'sd1000,   16'sd200},
    {1'b1, 2'd1, 1'b0, 16'sd300,    -16'sd400},
    {1'b1, 2'd1, 1'b0, -16'sd1200,  16'sd50},
    {1'b1, 2'd1, 1'b0, 16'sd7,      16'sd9},
    {1'b0, 2'd1, 1'b0, 16'sd0,      16'sd0},
    {1'b0, 2'd1, 1'b0, 16'sd0,      16'sd0},
    {1'b1, 2'd1, 1'b0, 16'sd100,    -16'sd100},
    {1'b1, 2'd1, 1'b0, 16'sd500,    16'sd600},
    {1'b1, 2'd1, 1'b1, 16'sd1000,   16'sd2000},
    {1'b1, 2'd1, 1'b1, -16'sd300,   16'sd123},
    {1'b1, 2'd1, 1'b1, 16'sd4000,   -16'sd4000},
    {1'b1, 2'd1, 1'b1, 16'sd11,     -16'sd22},
    {1'b1, 2'd2, 1'b0, 16'sd10000,  16'sd0},
    {1'b1, 2'd2, 1'b0, 16'sd10000,  16'sd0},
    {1'b1, 2'd2, 1'b0, -16'sd5000,  16'sd3000},
    {1'b1, 2'd2, 1'b0, 16'sd32767,  -16'sd32768},
    {1'b1, 2'd2, 1'b0, 16'sd1234,   -16'sd4321},
    {1'b1, 2'd2, 1'b0, -16'sd32768, -16'sd32768},
    {1'b0, 2'd2, 1'b0, 16'sd0,      16'sd0},
    {1'b1, 2'd2, 1'b0, 16'sd20000,  16'sd20000},
    {1'b1, 2'd2, 1'b0, -16'sd7,     16'sd13},
    {1'b1, 2'd2, 1'b0, 16'sd300,    16'sd300},
    {1'b1, 2'd2, 1'b1, 16'sd10000,  16'sd0},
    {1'b1, 2'd2, 1'b1, 16'sd10000,  16'sd0},
    {1'b1, 2'd2, 1'b1, -16'sd2500,  16'sd9000},
    {1'b1, 2'd2, 1'b1, 16'sd600,    -16'sd700},
    {1'b0, 2'd1, 1'b0, 16'sd0,      16'sd0},
    {1'b1, 2'd2, 1'b0, 16'sd4000,   16'sd4000},
    {1'b1, 2'd2, 1'b0, 16'sd4000,   16'sd4000},
    {1'b1, 2'd0, 1'b0, -16'sd32768, 16'sd32767},
    {1'b1, 2'd0, 1'b0, 16'sd123,    -16'sd456},
    {1'b0, 2'd0, 1'b0, 16'sd0,      16'sd0},
    {1'b1, 2'd0, 1'b0, 16'sd0,      -16'sd1},
    {1'b1, 2'd3, 1'b0, 16'sd555,    -16'sd666},
    {1'b1, 2'd3, 1'b0, -16'sd32768, -16'sd32768},
    {1'b1, 2'd1, 1'b0, -16'sd32768, 16'sd5},
    {1'b1, 2'd1, 1'b0, 16'sd0,      -16'sd32768},
    {1'b1, 2'd1, 1'b0, -16'sd32768, -16'sd32768},
    {1'b1, 2'd1, 1'b0, 16'sd32767,  -16'sd32768},
    {1'b1, 2'd1, 1'b0, -16'sd32768, 16'sd1},
    {1'b1, 2'd1, 1'b0, 16'sd3,      -16'sd32768}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inI = '0, inQ = '0;
  logic [1:0] modeSel = 2'd0;
  logic sbDown = 1'b0;
  logic outValid;
  logic signed [DW-1:0] outI, outQ;

  int checks = 0;
  int fails = 0;

  int mPhase = 0;
  logic [1:0] mLast = 2'd0;
  bit modeJump = 1'b0;
  bit gapSeen = 1'b0;
  bit pV [2] = '{1'b0, 1'b0};
  int pI [2] = '{0, 0};
  int pQ [2] = '{0, 0};
  string pTag [2] = '{"R1", "R1"};

  always #2 clk = ~clk;

  coarse_upconv i_coarse_upconv (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inI      (inI),
    .inQ      (inQ),
    .modeSel  (modeSel),
    .sbDown   (sbDown),
    .outValid (outValid),
    .outI     (outI),
    .outQ     (outQ)
  );

  function automatic int clip(input int v, inout bit hit);
    if (v > 32767)  begin hit = 1'b1; return 32767;  end
    if (v < -32768) begin hit = 1'b1; return -32768; end
    return v;
  endfunction

  function automatic void model(input logic [1:0] m, input int ph, input int i, input int q,
                                output int oi, output int oq, output bit hit);
    int a, b, t;
    a = i; b = q; hit = 1'b0;
    if (m == 2'd1 || m == 2'd2) begin
      if (ph % 2 == 1) begin
        a = ((i - q) * 23170 + 16384) >>> 15;
        b = ((i + q) * 23170 + 16384) >>> 15;
      end
      for (int r = 0; r < ph / 2; r++) begin
        t = a; a = -b; b = t;
      end
    end
    oi = clip(a, hit);
    oq = clip(b, hit);
  endfunction

  function automatic int stepOf(input logic [1:0] m, input logic d);
    int s;
    s = (m == 2'd1) ? 2 : (m == 2'd2) ? 1 : 0;
    return d ? -s : s;
  endfunction

  function automatic string modeTag(input logic [1:0] m, input logic d);
    if (m == 2'd0) return "R1";
    if (m == 2'd3) return "R9";
    if (m == 2'd2) return "R4";
    return d ? "R3" : "R2";
  endfunction

  task automatic checkOut();
    checks++;
    if (outValid !== pV[1]) begin
      fails++;
      $display("FAIL R1: outValid=%0b expected %0b", outValid, pV[1]);
    end
    if (pV[1]) begin
      checks++;
      if (outI !== DW'(pI[1]) || outQ !== DW'(pQ[1])) begin
        fails++;
        $display("FAIL %s: out=(%0d,%0d) expected (%0d,%0d)",
                 pTag[1], outI, outQ, pI[1], pQ[1]);
      end
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic d, input int i, input int q);
    int oi, oq;
    bit hit;
    string tag;
    oi = 0; oq = 0; hit = 1'b0; tag = "R1";
    @(negedge clk);
    checkOut();
    if (m != mLast) begin mPhase = 0; modeJump = 1'b1; end
    mLast = m;
    if (v) begin
      model(m, mPhase, i, q, oi, oq, hit);
      if (hit)           tag = "R7";
      else if (modeJump) tag = "R6";
      else if (gapSeen)  tag = "R5";
      else               tag = modeTag(m, d);
      modeJump = 1'b0;
      gapSeen  = 1'b0;
      mPhase   = (mPhase + stepOf(m, d) + 8) % 8;
    end else begin
      gapSeen = 1'b1;
    end
    pV[1] = pV[0]; pI[1] = pI[0]; pQ[1] = pQ[0]; pTag[1] = pTag[0];
    pV[0] = v;     pI[0] = oi;    pQ[0] = oq;    pTag[0] = tag;
    inValid = v; modeSel = m; sbDown = d;
    inI = DW'(i); inQ = DW'(q);
  endtask

  task automatic resetModel();
    mPhase = 0; mLast = 2'd0; modeJump = 1'b0; gapSeen = 1'b0;
    pV = '{1'b0, 1'b0}; pI = '{0, 0}; pQ = '{0, 0};
  endtask

  task automatic checkResetState();
    checks++;
    if (outValid !== 1'b0 || outI !== '0 || outQ !== '0) begin
      fails++;
      $display("FAIL R8: outValid=%0b out=(%0d,%0d) expected 0 (0,0)", outValid, outI, outQ);
    end
  endtask

  initial begin
    #(4 * 50000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    resetModel();

    // table walk: R1 to R7, R9
    for (int n = 0; n < NV; n++) begin
      drive(VEC[n][35], VEC[n][34:33], VEC[n][32],
            int'($signed(VEC[n][31:16])), int'($signed(VEC[n][15:0])));
    end
    drive(1'b0, 2'd1, 1'b0, 0, 0);
    drive(1'b0, 2'd1, 1'b0, 0, 0);

    // R6: sideband flip alone keeps the phase going
    drive(1'b1, 2'd1, 1'b0, 40, 30);
    drive(1'b1, 2'd1, 1'b1, 40, 30);
    drive(1'b1, 2'd1, 1'b0, 40, 30);
    drive(1'b0, 2'd1, 1'b0, 0, 0);
    drive(1'b0, 2'd1, 1'b0, 0, 0);

    // R8: reset in the middle of a quarter-rate run
    drive(1'b1, 2'd1, 1'b0, 900, -800);
    drive(1'b1, 2'd1, 1'b0, 900, -800);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    checkResetState();
    @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    resetModel();
    drive(1'b1, 2'd1, 1'b0, 900, -800);
    drive(1'b1, 2'd1, 1'b0, 900, -800);
    drive(1'b0, 2'd1, 1'b0, 0, 0);
    drive(1'b0, 2'd1, 1'b0, 0, 0);
    drive(1'b0, 2'd1, 1'b0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule